// File: doc/BRIEF.md
# External Interrupt Polarity Normalizer

This block sits between a small set of external interrupt pins (two by default) and a downstream interrupt controller that only understands active-high levels and rising edges. Software gives every pin its own configuration word, holding an enable, a level/edge select and a polarity select. The block then turns what arrives on the pin into the form the downstream side expects. An active-low level is inverted so it appears as an active-high level. A falling edge appears as a single-cycle pulse, just as a rising edge does.

Every pin first passes through a two-flop synchronizer, so the outputs lag the pins by two clock edges. The register interface is a plain single-cycle bus made of an address, a write strobe, write data and combinational read data. It has no handshake, because every access completes in the cycle it is presented. A configuration word reads back exactly what was stored, so software can save it and later restore it. An all-zero word switches a line off.

Top module: `xirq_normalizer`

## Requirements
- R1: A synchronous active-high reset clears every configuration word and synchronizer flop; after reset every output is low and every configuration word reads 0.
- R2: The configuration word of line i is at byte address 0x4 + 4*i. Bit 16 is the enable, bit 9 selects level sensing (1) or edge sensing (0), and bit 8 is the polarity select. These three bits read back as written; all other bits are ignored on write and read as 0.
- R3: Address 0x0 and every address that maps to no line read as 0, and writes to them leave all configuration words unchanged.
- R4: While a line's enable bit is 0, including after an all-zero write, its output stays low whatever its pin does.
- R5: Level mode with polarity 1: the output equals the pin value sampled two clock edges earlier (active-high level).
- R6: Level mode with polarity 0: the output equals the inverse of the pin value sampled two clock edges earlier (an active-low request becomes an active-high output).
- R7: Edge mode with polarity 0: each rising edge on the pin gives an output high for exactly one cycle, in the third cycle after the edge is set up ahead of a clock.
- R8: Edge mode with polarity 1: each falling edge on the pin gives an output high for exactly one cycle, with the same latency as R7; rising edges give nothing.
- R9: Lines are independent: one line's configuration and pin never affect another line's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write takes effect at the next rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_irq_in | input | NUM_LINES (2) | Asynchronous external interrupt pins |
| irq_out | output | NUM_LINES (2) | Normalized requests: active-high level or one-cycle pulse |

## Verification
A stored mode or polarity bit that is wrong shows up at once at two places. The read data gives back the wrong word in the same cycle, and the output of a level-mode line is inverted in the first cycle it is compared. A stale synchronizer or edge-history flop shows up as an output that is one cycle early or late, or as a pulse that lasts two cycles, in the cycle where the edge should appear. Because of this, the bench compares both outputs against an independent model in every cycle of a long random run, with writes to mapped and unmapped addresses mixed in.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 16;
  localparam int LVL_BIT = 9;
  localparam int POL_BIT = 8;
  localparam logic [DATA_W-1:0] CFG_MASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << LVL_BIT) | (DATA_W'(1) << POL_BIT);

  typedef struct packed {
    logic en;
    logic lvl;
    logic pol;
  } line_cfg_t;

  function automatic line_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
    line_cfg_t c;
    c.en  = w[EN_BIT];
    c.lvl = w[LVL_BIT];
    c.pol = w[POL_BIT];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_to_word(input line_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT]  = c.en;
    w[LVL_BIT] = c.lvl;
    w[POL_BIT] = c.pol;
    return w;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_cfg_regs.sv
module xirq_cfg_regs
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_we,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  output line_cfg_t [NUM_LINES-1:0]       cfg_o
);
  localparam int STRIDE = 4;

  logic [NUM_LINES-1:0] hit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_reg
    assign hit[i] = (bus_addr == ADDR_W'(STRIDE * (i + 1)));

    always_ff @(posedge clk) begin
      if (rst)
        cfg_o[i] <= '0;
      else if (bus_we && hit[i])
        cfg_o[i] <= word_to_cfg(bus_wdata);
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_we && hit[i]) |=> (cfg_to_word(cfg_o[i]) == ($past(bus_wdata) & CFG_MASK)));

    p_unmapped_write_r3: assert property (@(posedge clk) disable iff (rst)
      (!(bus_we && hit[i])) |=> $stable(cfg_o[i]));

    p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (cfg_o[i] == '0));
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (hit[i]) bus_rdata = cfg_to_word(cfg_o[i]);
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~CFG_MASK) == '0);

  p_global_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == '0) |-> (bus_rdata == '0));
endmodule

// File: rtl/xirq_line_shaper.sv
module xirq_line_shaper
  import xirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_cfg_t cfg_i,
  input  logic      sync_i,
  input  logic      raw_i,
  output logic      irq_o
);
  logic       prev_q;
  logic       rise, fall, pulse, level_out;
  logic [1:0] warm_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_i;
  end

  assign rise      = sync_i & ~prev_q;
  assign fall      = ~sync_i & prev_q;
  assign pulse     = cfg_i.pol ? fall : rise;
  assign level_out = sync_i ~^ cfg_i.pol;
  assign irq_o     = cfg_i.en & (cfg_i.lvl ? level_out : pulse);

  // cycles since reset, saturating, for the latency check below
  always_ff @(posedge clk) begin
    if (rst)                 warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R5 and R6: level output follows the pin two edges later, polarity corrected
  p_level_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd2 && cfg_i.en && cfg_i.lvl) |-> (irq_o == ($past(raw_i, 2) ~^ cfg_i.pol)));

  // R7 and R8: an edge request lasts exactly one cycle
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.en && !cfg_i.lvl && irq_o) |=> (!irq_o || !$stable(cfg_i)));

  p_disabled_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_i.en) |-> !irq_o);
endmodule

// File: rtl/xirq_normalizer.sv
module xirq_normalizer
  import xirq_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] ext_irq_in,
  output logic [NUM_LINES-1:0] irq_out
);
  line_cfg_t [NUM_LINES-1:0] cfg;
  logic      [NUM_LINES-1:0] pin_sync;

  xirq_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_o(cfg)
  );

  xirq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .async_i(ext_irq_in), .sync_o(pin_sync)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    xirq_line_shaper i_shaper (
      .clk(clk), .rst(rst),
      .cfg_i(cfg[i]), .sync_i(pin_sync[i]), .raw_i(ext_irq_in[i]),
      .irq_o(irq_out[i])
    );
  end

  p_reset_outputs_low_r1: assert property (@(posedge clk)
    rst |=> (irq_out == '0));
endmodule

// File: tb/test_xirq_normalizer.sv
module test_xirq_normalizer;
  localparam int N = 2;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] ext_irq_in = '0;
  logic [N-1:0] irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  xirq_normalizer i_xirq_normalizer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_irq_in(ext_irq_in), .irq_out(irq_out)
  );

  // independent reference model built from the requirements
  logic [2:0] m_cfg [N];   // {en, lvl, pol}
  logic [N-1:0] m_s1, m_s2, m_prev;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) m_cfg[i] <= 3'b000;
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
    end else begin
      m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= ext_irq_in;
      for (int i = 0; i < N; i++)
        if (bus_we && bus_addr == 8'(4 * (i + 1)))
          m_cfg[i] <= {bus_wdata[16], bus_wdata[9], bus_wdata[8]};
    end
  end

  function automatic logic exp_out(input logic [2:0] c, input logic s, input logic p);
    if (!c[2]) return 1'b0;
    if (c[1])  return c[0] ? s : ~s;
    return c[0] ? (~s & p) : (s & ~p);
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] w);
    return w & 32'h0001_0300;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk); tick(); tick();
    // R1 reset state
    check(irq_out == '0, "R1 outputs after reset", 32'(irq_out), 0);
    rst = 1'b0;
    rd(8'h04, d); check(d == 0, "R1 cfg0 after reset", d, 0);
    rd(8'h08, d); check(d == 0, "R1 cfg1 after reset", d, 0);

    // R2 readback and reserved bits
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check(d == 32'h0001_0300, "R2 masked readback", d, 32'h0001_0300);
    wr(8'h08, 32'h0000_0100);
    rd(8'h08, d); check(d == 32'h0000_0100, "R2 line1 readback", d, 32'h0000_0100);

    // R3 global and unmapped
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0000_0000);
    rd(8'h00, d); check(d == 0, "R3 global reads zero", d, 0);
    rd(8'h0C, d); check(d == 0, "R3 unmapped reads zero", d, 0);
    rd(8'h04, d); check(d == 32'h0001_0300, "R3 cfg0 untouched", d, 32'h0001_0300);
    rd(8'h08, d); check(d == 32'h0000_0100, "R3 cfg1 untouched", d, 32'h0000_0100);

    // R5 level high on line 0 (cfg0 = en,lvl,pol already)
    wr(8'h08, 32'h0); ext_irq_in = 2'b00; tick(); tick(); tick();
    ext_irq_in[0] = 1'b1;
    tick(); check(irq_out[0] == 1'b0, "R5 not yet after one edge", 32'(irq_out[0]), 0);
    tick(); check(irq_out[0] == 1'b1, "R5 level high after two edges", 32'(irq_out[0]), 1);
    check(irq_out[1] == 1'b0, "R9 line1 unaffected", 32'(irq_out[1]), 0);
    ext_irq_in[0] = 1'b0; tick(); tick();
    check(irq_out[0] == 1'b0, "R5 level released", 32'(irq_out[0]), 0);

    // R6 level low on line 1
    wr(8'h08, 32'h0001_0200); tick();
    check(irq_out[1] == 1'b1, "R6 low pin gives high output", 32'(irq_out[1]), 1);
    ext_irq_in[1] = 1'b1; tick(); tick();
    check(irq_out[1] == 1'b0, "R6 high pin gives low output", 32'(irq_out[1]), 0);

    // R4 disable
    wr(8'h08, 32'h0); ext_irq_in[1] = 1'b0; tick(); tick();
    check(irq_out[1] == 1'b0, "R4 all-zero write disables", 32'(irq_out[1]), 0);
    wr(8'h04, 32'h0000_0300); ext_irq_in[0] = 1'b1; tick(); tick(); tick();
    check(irq_out[0] == 1'b0, "R4 enable clear holds low", 32'(irq_out[0]), 0);

    // R7 rising edge on line 0
    ext_irq_in[0] = 1'b0; wr(8'h04, 32'h0001_0000); tick(); tick();
    ext_irq_in[0] = 1'b1;
    tick(); check(irq_out[0] == 1'b0, "R7 no pulse after one edge", 32'(irq_out[0]), 0);
    tick(); check(irq_out[0] == 1'b1, "R7 pulse present", 32'(irq_out[0]), 1);
    tick(); check(irq_out[0] == 1'b0, "R7 pulse one cycle", 32'(irq_out[0]), 0);
    ext_irq_in[0] = 1'b0; tick(); tick(); tick();
    check(irq_out[0] == 1'b0, "R7 falling edge ignored", 32'(irq_out[0]), 0);

    // R8 falling edge on line 0
    ext_irq_in[0] = 1'b1; wr(8'h04, 32'h0001_0100); tick(); tick(); tick();
    check(irq_out[0] == 1'b0, "R8 rising edge ignored", 32'(irq_out[0]), 0);
    ext_irq_in[0] = 1'b0;
    tick(); tick(); check(irq_out[0] == 1'b1, "R8 falling pulse", 32'(irq_out[0]), 1);
    tick(); check(irq_out[0] == 1'b0, "R8 pulse one cycle", 32'(irq_out[0]), 0);

    // random phase against the model: R5 R6 R7 R8 R9 R4 R2
    model_on = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int i = 0; i < N; i++)
        check(irq_out[i] == exp_out(m_cfg[i], m_s2[i], m_prev[i]),
              "R9 random line output", 32'(irq_out[i]), 32'(exp_out(m_cfg[i], m_s2[i], m_prev[i])));
      bus_addr = 8'(4 * ($urandom % 4));
      #1;
      if (bus_addr == 8'h04 || bus_addr == 8'h08) begin
        automatic int li = (bus_addr == 8'h04) ? 0 : 1;
        check(bus_rdata == exp_word({15'b0, m_cfg[li][2], 6'b0, m_cfg[li][1:0], 8'b0}),
              "R2 random readback", bus_rdata,
              {15'b0, m_cfg[li][2], 6'b0, m_cfg[li][1:0], 8'b0});
      end else begin
        check(bus_rdata == 0, "R3 random unmapped read", bus_rdata, 0);
      end
      bus_we = (($urandom % 8) == 0);
      bus_wdata = $urandom;
      ext_irq_in = N'($urandom);
      @(posedge clk); @(negedge clk);
    end
    bus_we = 1'b0;
    finish_run();
  end
endmodule